// File: doc/BRIEF.md
# External Bus Hand-Off Arbiter

This block decides when a controller that normally owns the external memory bus gives it to another master, and when it takes the bus back. Another master asks for the bus by pulling an active-low request line low. The request passes through a synchronizer. It is then granted only when no bus cycle is running, no indivisible sequence is under way, the software lock is clear, and any DMA burst allows it. The grant is shown on an active-low acknowledge output, which changes only on clock edges.

If an SDRAM bank is still open when release is due, the block first asks the memory sequencer for a precharge-all command. It hands the bus over only after that command reports completion. While the bus is granted away, the bus drivers are disabled and internal requesters are stalled. When the request line returns high, the acknowledge is withdrawn, the drivers come back, and pending internal work resumes on that same clock edge.

Top module: `xbus_handoff`

## Requirements
- R1: After reset, and while no request is seen, back_no is 1, drv_en_o is 1, stall_o is 0 and pall_req_o is 0.
- R2: The request line breq_ni goes through a two-flop synchronizer. When it falls and nothing blocks release and bank_open_i is 0, back_no goes to 0 and drv_en_o goes to 0 on the third rising clock edge after the fall.
- R3: While cyc_busy_i is 1, release is held off. Release follows on the first rising edge after cyc_busy_i returns to 0 with the request still asserted.
- R4: Release is blocked while any bit of seq_hold_i is 1. These bits cover line fill, write-back, atomic test-and-set, split wide access, 16-byte DMA and NAND access.
- R5: Release is blocked while lock_cfg_i is 1.
- R6: While dma_burst_i is 1, release is blocked if burst_yield_i is 0 and allowed if burst_yield_i is 1.
- R7: If bank_open_i is 1 when release is due, pall_req_o goes to 1 on the edge where release would have happened, while back_no stays 1. back_no falls on the first rising edge at which pall_done_i is sampled 1.
- R8: When breq_ni returns high, on the third rising edge back_no returns to 1, drv_en_o returns to 1 and stall_o returns to 0.
- R9: stall_o is 1 from the cycle in which release is decided, through any precharge and the whole grant.
- R10: A request withdrawn while release is blocked, or during the precharge wait, produces no acknowledge; the block returns to owning the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| breq_ni | input | 1 | External bus request, active low, asynchronous |
| cyc_busy_i | input | 1 | A bus cycle is in progress |
| seq_hold_i | input | NSEQ | Indivisible-sequence flags, any bit blocks release |
| lock_cfg_i | input | 1 | Software bus lock |
| dma_burst_i | input | 1 | DMA burst transfer in progress |
| burst_yield_i | input | 1 | 1 lets a request be accepted mid-burst |
| bank_open_i | input | 1 | Some SDRAM bank is open |
| pall_done_i | input | 1 | Precharge-all command completed |
| back_no | output | 1 | Bus acknowledge, active low |
| pall_req_o | output | 1 | Request for a precharge-all command |
| drv_en_o | output | 1 | Enable for address, data and strobe drivers |
| stall_o | output | 1 | Stall to internal access requesters |

## Verification
The bench sweeps all 2048 combinations of the blocking flags, the lock, the busy cycle, the burst and yield bits and the open-bank flag. For each one it predicts from the requirements whether release happens, and whether precharge comes first. A design that ignored one hold bit, or read the yield bit with the wrong polarity, would raise the acknowledge during an indivisible sequence. A design that skipped the precharge step would hand over a bus with a bank still open. Directed cases count synchronizer latency exactly: a missing flop would acknowledge one edge early. The cases also withdraw a request during a blocked period and during the precharge wait, where a design that latched the request would pulse the acknowledge.

// File: rtl/xbh_pkg.sv
package xbh_pkg;
   typedef enum logic [1:0] {
      XBH_OWN   = 2'd0,
      XBH_PALL  = 2'd1,
      XBH_GRANT = 2'd2
   } xbh_state_e;
endpackage

// File: rtl/xbh_sync.sv
module xbh_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   initial begin
      assert (STAGES >= 2) else $error("xbh_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xbh_gate.sv
module xbh_gate #(
   parameter int NSEQ = 6
) (
   input  logic            cyc_busy_i,
   input  logic [NSEQ-1:0] seq_hold_i,
   input  logic            lock_cfg_i,
   input  logic            dma_burst_i,
   input  logic            burst_yield_i,
   output logic            hold_o
);
   initial begin
      assert (NSEQ >= 1) else $error("xbh_gate: NSEQ must be at least 1");
   end

   logic [NSEQ:0] seq_or;

   assign seq_or[0] = 1'b0;
   genvar i;
   generate
      for (i = 0; i < NSEQ; i++) begin : g_or
         assign seq_or[i+1] = seq_or[i] | seq_hold_i[i];
      end
   endgenerate

   assign hold_o = cyc_busy_i | seq_or[NSEQ] | lock_cfg_i
                 | (dma_burst_i & ~burst_yield_i);
endmodule

// File: rtl/xbh_fsm.sv
module xbh_fsm
   import xbh_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   input  logic hold_i,
   input  logic bank_open_i,
   input  logic pall_done_i,
   output logic back_no,
   output logic pall_req_o,
   output logic drv_en_o,
   output logic stall_o
);
   xbh_state_e state_q, state_d;
   logic take_now;

   assign take_now = (state_q == XBH_OWN) & req_i & ~hold_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         XBH_OWN: begin
            if (take_now) state_d = bank_open_i ? XBH_PALL : XBH_GRANT;
         end
         XBH_PALL: begin
            if (!req_i)           state_d = XBH_OWN;
            else if (pall_done_i) state_d = XBH_GRANT;
         end
         XBH_GRANT: begin
            if (!req_i) state_d = XBH_OWN;
         end
         default: state_d = XBH_OWN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= XBH_OWN;
      else         state_q <= state_d;
   end

   assign back_no    = (state_q != XBH_GRANT);
   assign drv_en_o   = (state_q != XBH_GRANT);
   assign pall_req_o = (state_q == XBH_PALL);
   assign stall_o    = (state_q != XBH_OWN) | take_now;

   // R2
   ack_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(back_no) |-> $past(req_i));

   // R4
   hold_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == XBH_OWN && hold_i) |=> back_no);

   // R7
   pall_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == XBH_OWN && bank_open_i) |=> back_no);

   // R8
   resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!back_no && !req_i) |=> (back_no && drv_en_o));

   // R9
   stall_in_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !back_no |-> stall_o);

   // R10
   abort_pall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pall_req_o && !req_i) |=> (back_no && !pall_req_o));
endmodule

// File: rtl/xbus_handoff.sv
module xbus_handoff #(
   parameter int NSEQ        = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            breq_ni,
   input  logic            cyc_busy_i,
   input  logic [NSEQ-1:0] seq_hold_i,
   input  logic            lock_cfg_i,
   input  logic            dma_burst_i,
   input  logic            burst_yield_i,
   input  logic            bank_open_i,
   input  logic            pall_done_i,
   output logic            back_no,
   output logic            pall_req_o,
   output logic            drv_en_o,
   output logic            stall_o
);
   logic req_s;
   logic hold_w;

   xbh_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (~breq_ni),
      .q_o    (req_s)
   );

   xbh_gate #(.NSEQ(NSEQ)) u_gate (
      .cyc_busy_i    (cyc_busy_i),
      .seq_hold_i    (seq_hold_i),
      .lock_cfg_i    (lock_cfg_i),
      .dma_burst_i   (dma_burst_i),
      .burst_yield_i (burst_yield_i),
      .hold_o        (hold_w)
   );

   xbh_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_s),
      .hold_i      (hold_w),
      .bank_open_i (bank_open_i),
      .pall_done_i (pall_done_i),
      .back_no     (back_no),
      .pall_req_o  (pall_req_o),
      .drv_en_o    (drv_en_o),
      .stall_o     (stall_o)
   );
endmodule

// File: tb/xbus_handoff_tb.sv
module xbus_handoff_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NSEQ = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic breq_n = 1'b1, busy = 1'b0, lock = 1'b0, burst = 1'b0, yield_c = 1'b0;
   logic bank = 1'b0, pdone = 1'b0;
   logic [NSEQ-1:0] seq = '0;
   logic back_n, pall_req, drv_en, stall;
   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xbus_handoff #(.NSEQ(NSEQ), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .breq_ni(breq_n), .cyc_busy_i(busy),
      .seq_hold_i(seq), .lock_cfg_i(lock), .dma_burst_i(burst),
      .burst_yield_i(yield_c), .bank_open_i(bank), .pall_done_i(pdone),
      .back_no(back_n), .pall_req_o(pall_req), .drv_en_o(drv_en), .stall_o(stall)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic clear_all();
      busy = 0; lock = 0; burst = 0; yield_c = 0; bank = 0; seq = '0; pdone = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1", back_n, 1'b1, "back_no");
      chk("R1", drv_en, 1'b1, "drv_en_o");
      chk("R1", stall, 1'b0, "stall_o");
      chk("R1", pall_req, 1'b0, "pall_req_o");

      // R2 exact latency: not yet after two edges, granted after three
      breq_n = 0;
      step(2);
      chk("R2", back_n, 1'b1, "back_no after 2 edges");
      step(1);
      chk("R2", back_n, 1'b0, "back_no after 3 edges");
      chk("R2", drv_en, 1'b0, "drv_en_o granted");
      breq_n = 1;
      step(3);
      chk("R8", back_n, 1'b1, "back_no after release");
      chk("R8", stall, 1'b0, "stall_o after release");

      // R3 busy cycle delays release until it completes
      busy = 1; breq_n = 0;
      step(6);
      chk("R3", back_n, 1'b1, "back_no while busy");
      busy = 0;
      step(1);
      chk("R3", back_n, 1'b0, "back_no after cycle ends");
      breq_n = 1;
      step(3);

      // R10 withdrawn while blocked
      lock = 1; breq_n = 0;
      step(5);
      breq_n = 1;
      step(4);
      lock = 0;
      for (int k = 0; k < 4; k++) begin
         step(1);
         chk("R10", back_n, 1'b1, "no ack after withdrawn blocked request");
      end
      chk("R10", stall, 1'b0, "stall_o after abort");

      // R10 withdrawn during precharge wait
      bank = 1; breq_n = 0;
      step(3);
      chk("R7", pall_req, 1'b1, "pall_req_o raised");
      breq_n = 1;
      for (int k = 0; k < 3; k++) begin
         chk("R10", back_n, 1'b1, "no ack during precharge abort");
         step(1);
      end
      chk("R10", pall_req, 1'b0, "pall_req_o dropped after abort");
      chk("R10", back_n, 1'b1, "back_no after precharge abort");
      clear_all();
      step(1);

      // Sweep R4 R5 R6 R7 R9 R2 R8
      for (int v = 0; v < 2048; v++) begin
         logic blocked;
         seq = v[5:0]; lock = v[6]; busy = v[7]; burst = v[8]; yield_c = v[9]; bank = v[10];
         blocked = busy | (|seq) | lock | (burst & ~yield_c);
         breq_n = 0;
         step(2);
         chk("R9", stall, ~blocked, "stall_o at decision");
         step(1);
         if (blocked) begin
            chk("R4", back_n, 1'b1, "back_no blocked");
            chk("R5", pall_req, 1'b0, "pall_req_o blocked");
            chk("R6", drv_en, 1'b1, "drv_en_o blocked");
         end else if (bank) begin
            chk("R7", pall_req, 1'b1, "pall_req_o before grant");
            chk("R7", back_n, 1'b1, "back_no during precharge");
            chk("R9", stall, 1'b1, "stall_o during precharge");
            step(1);
            chk("R7", back_n, 1'b1, "back_no waits for pall_done_i");
            pdone = 1;
            step(1);
            pdone = 0;
            chk("R7", back_n, 1'b0, "back_no after precharge");
            chk("R7", pall_req, 1'b0, "pall_req_o after precharge");
            chk("R2", drv_en, 1'b0, "drv_en_o granted");
         end else begin
            chk("R2", back_n, 1'b0, "back_no granted");
            chk("R2", drv_en, 1'b0, "drv_en_o granted");
            chk("R9", stall, 1'b1, "stall_o granted");
         end
         breq_n = 1;
         step(3);
         chk("R8", back_n, 1'b1, "back_no after request drop");
         chk("R8", drv_en, 1'b1, "drv_en_o after request drop");
         chk("R8", stall, 1'b0, "stall_o after request drop");
         clear_all();
         step(1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule